// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

The block turns one character into an asynchronous serial frame on a single output line. Each frame has one start bit, a 7-bit or 8-bit character field, an optional parity slot, and one or two stop bits. Five configuration inputs set the frame layout at run time:

- the character length;
- the parity mode (even, odd, forced zero, or none);
- the number of stop bits;
- the bit order (least-significant first or most-significant first);
- the line polarity (normal or inverted).

The character comes in over a valid/ready handshake. Every configuration input and the character are captured on the cycle the handshake completes, so a change during a frame does not affect the frame in flight. Bit timing comes from an external baud-tick strobe. Each bit slot lasts a fixed number of ticks, and cycles without a tick do not move the frame forward. A busy flag stays high from the accepted handshake until the last stop bit has finished.

Top module: `uart_frame_tx`

## Requirements
- R1: While no frame is in progress, `busy` is 0, `in_ready` is 1 and `tx_line` sits at the idle level (1 with `cfg_invert`=0). This is also the state after reset.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. After that edge `busy` is 1 and `in_ready` is 0 until the frame ends. `in_valid` and `in_data` are ignored during that time.
- R3: The first slot of every frame is a single start bit at the non-idle level (raw 0).
- R4: `cfg_eight_bits`=1 sends 8 character bits (D7..D0). `cfg_eight_bits`=0 sends 7 (D6..D0), and D7 never appears on the line.
- R5: With `cfg_msb_first`=0, character bits are sent D0 first, in ascending order.
- R6: With `cfg_msb_first`=1, character bits are sent from the top active bit down: D7 to D0 for 8 bits, D6 to D0 for 7 bits.
- R7: `cfg_parity` encoding: 00 none, 01 even, 10 odd, 11 forced zero. The parity bit follows the last character bit. It is computed over the active character bits only, so that even or odd mode gives an even or odd total number of ones across the character bits and the parity bit. Forced zero always sends raw 0.
- R8: With `cfg_parity`=00 there is no parity slot, and the first stop bit follows the last character bit directly.
- R9: The frame ends with one stop bit (raw 1), or two when `cfg_two_stop`=1.
- R10: Every slot lasts exactly 16 cycles with `baud_tick`=1. The line does not change on cycles without a tick.
- R11: With `cfg_invert`=1, the line carries the inverse of every raw level: the idle level, start, data, parity and stop bits.
- R12: Configuration and data are taken from the accepting edge. Changing any configuration input during a frame does not alter that frame.
- R13: `busy` falls and `in_ready` rises only at the tick that ends the last stop bit, exactly 16 × (slot count) ticks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle baud strobe from an external divider |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter can accept a character |
| in_data | input | 8 | Character to send |
| cfg_eight_bits | input | 1 | 1: 8 character bits, 0: 7 |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 zero |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_msb_first | input | 1 | 1: most-significant character bit first |
| cfg_invert | input | 1 | 1: invert the line level, idle included |
| busy | output | 1 | Frame in progress |
| tx_line | output | 1 | Serial output |

## Verification
The assertions assume that `baud_tick` is a clean one-cycle-per-tick strobe sampled on the clock, and that the idle level follows the live `cfg_invert` while the in-frame level follows the captured value. The stimulus sweeps all 64 format combinations with several characters. Some frames use a tick every cycle and others one tick every third cycle. On some frames the configuration and data inputs are changed and `in_valid` is held high partway through the frame. `in_valid` is always dropped well before the frame ends, so no second handshake occurs while the end of the frame is being checked.

// File: rtl/uart_frame_tx_pkg.sv
// Shared types for the configurable UART frame transmitter.
package uart_frame_tx_pkg;

    // Parity selection as presented on cfg_parity.
    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } parity_mode_e;

    // Frame sequencer slots.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_CHAR,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Run-time frame format as captured at acceptance.
    typedef struct packed {
        logic         eight_bits;
        parity_mode_e parity;
        logic         two_stop;
        logic         msb_first;
        logic         invert;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_char_prep.sv
// Character preparation (combinational).
// Turns the offered character into a shift word that always leaves from bit 0,
// so the sequencer never needs to know the bit order. It also works out the
// parity bit over the active character bits and the index of the last
// character bit.
// Assumes: the short character mode is one bit narrower than DATA_W.
module uart_tx_char_prep
    import uart_frame_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              eight_bits,
    input  logic              msb_first,
    input  parity_mode_e      parity,
    output logic [DATA_W-1:0] shift_word,
    output logic              parity_bit,
    output logic [IDX_W-1:0]  last_idx
);

    logic [DATA_W-1:0] act_mask;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] rev_full;
    logic [DATA_W-1:0] rev_short;

    // Full-width mirror, used for MSB-first with the long character.
    for (genvar g = 0; g < DATA_W; g++) begin : g_rev_full
        assign rev_full[g] = data[DATA_W-1-g];
    end

    // Short mirror: the top active bit lands in bit 0, and the top slot stays 0.
    for (genvar g = 0; g < DATA_W-1; g++) begin : g_rev_short
        assign rev_short[g] = data[DATA_W-2-g];
    end
    assign rev_short[DATA_W-1] = 1'b0;

    // Active-bit mask and masked character.
    always_comb begin
        act_mask = '1;
        if (!eight_bits) act_mask[DATA_W-1] = 1'b0;
        masked = data & act_mask;
    end

    // Pick the shift word by bit order and character length.
    always_comb begin
        if (!msb_first)      shift_word = masked;
        else if (eight_bits) shift_word = rev_full;
        else                 shift_word = rev_short;
    end

    // Parity over the active bits only.
    always_comb begin
        unique case (parity)
            PAR_EVEN: parity_bit = ^masked;
            PAR_ODD:  parity_bit = ~(^masked);
            default:  parity_bit = 1'b0;
        endcase
    end

    // Index of the last character bit.
    always_comb begin
        last_idx = eight_bits ? IDX_W'(DATA_W-1) : IDX_W'(DATA_W-2);
    end

endmodule

// File: rtl/uart_tx_bit_timer.sv
// Bit slot timer.
// Counts baud ticks while a frame runs and pulses bit_done on the tick that
// completes a slot. A clear (frame acceptance) restarts the count and takes
// priority over a tick in the same cycle.
// Assumes: TICKS_PER_BIT >= 2.
module uart_tx_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CNT_W = $clog2(TICKS_PER_BIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic bit_done
);

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last  = (cnt == CNT_W'(TICKS_PER_BIT-1));
    assign bit_done = run && tick && at_last && !clear;

    // Tick counter within the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clear)       cnt <= '0;
        else if (run && tick) cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/uart_tx_sequencer.sv
// Frame sequencer.
// Captures the prepared character and the format on acceptance, then walks
// start, character, optional parity and stop slots, one slot per bit_done.
// Drives the raw (uninverted) slot level and holds the captured polarity.
// Assumes: accept is only raised while the sequencer is idle.
module uart_tx_sequencer
    import uart_frame_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] shift_word,
    input  logic              parity_bit,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              has_parity,
    input  logic              two_stop,
    input  logic              invert,
    input  logic              bit_done,
    output logic              busy,
    output logic              raw_bit,
    output logic              held_invert
);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [IDX_W-1:0]  last_q;
    logic [IDX_W-1:0]  idx;
    logic              has_par_q;
    logic              two_stop_q;
    logic              stop_idx;

    assign busy = (state != ST_IDLE);

    // Slot walk and format capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            par_q       <= 1'b0;
            last_q      <= '0;
            idx         <= '0;
            has_par_q   <= 1'b0;
            two_stop_q  <= 1'b0;
            stop_idx    <= 1'b0;
            held_invert <= 1'b0;
        end else if (accept) begin
            state       <= ST_START;
            shreg       <= shift_word;
            par_q       <= parity_bit;
            last_q      <= last_idx;
            idx         <= '0;
            has_par_q   <= has_parity;
            two_stop_q  <= two_stop;
            stop_idx    <= 1'b0;
            held_invert <= invert;
        end else if (bit_done) begin
            unique case (state)
                ST_START: begin
                    state <= ST_CHAR;
                    idx   <= '0;
                end
                ST_CHAR: begin
                    shreg <= shreg >> 1;
                    if (idx == last_q) begin
                        state    <= has_par_q ? ST_PARITY : ST_STOP;
                        stop_idx <= 1'b0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_PARITY: begin
                    state    <= ST_STOP;
                    stop_idx <= 1'b0;
                end
                ST_STOP: begin
                    if (stop_idx || !two_stop_q) state <= ST_IDLE;
                    else                         stop_idx <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Raw level for the current slot.
    always_comb begin
        unique case (state)
            ST_START:  raw_bit = 1'b0;
            ST_CHAR:   raw_bit = shreg[0];
            ST_PARITY: raw_bit = par_q;
            default:   raw_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Configurable UART frame transmitter (top).
// Accepts a character over valid/ready, captures the run-time format, and
// serializes start, character, optional parity and stop bits at
// TICKS_PER_BIT baud ticks per slot. The idle level follows the live polarity
// input. The in-frame level follows the polarity captured at acceptance.
// Assumes: baud_tick is a single-cycle strobe synchronous to clk.
module uart_frame_tx
    import uart_frame_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_eight_bits,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    output logic              busy,
    output logic              tx_line
);

    frame_cfg_t        cfg_now;
    logic              accept;
    logic [DATA_W-1:0] shift_word;
    logic              parity_bit;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_done;
    logic              raw_bit;
    logic              held_invert;

    // Gather the live format inputs into one record.
    always_comb begin
        cfg_now.eight_bits = cfg_eight_bits;
        cfg_now.parity     = parity_mode_e'(cfg_parity);
        cfg_now.two_stop   = cfg_two_stop;
        cfg_now.msb_first  = cfg_msb_first;
        cfg_now.invert     = cfg_invert;
    end

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    uart_tx_char_prep #(.DATA_W(DATA_W)) i_prep (
        .data       (in_data),
        .eight_bits (cfg_now.eight_bits),
        .msb_first  (cfg_now.msb_first),
        .parity     (cfg_now.parity),
        .shift_word (shift_word),
        .parity_bit (parity_bit),
        .last_idx   (last_idx)
    );

    uart_tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (busy),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    uart_tx_sequencer #(.DATA_W(DATA_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .shift_word  (shift_word),
        .parity_bit  (parity_bit),
        .last_idx    (last_idx),
        .has_parity  (cfg_now.parity != PAR_NONE),
        .two_stop    (cfg_now.two_stop),
        .invert      (cfg_now.invert),
        .bit_done    (bit_done),
        .busy        (busy),
        .raw_bit     (raw_bit),
        .held_invert (held_invert)
    );

    // Apply polarity: captured during a frame, live while idle.
    always_comb begin
        tx_line = raw_bit ^ (busy ? held_invert : cfg_invert);
    end

endmodule

// File: rtl/uart_frame_tx_checker.sv
// Protocol checker for uart_frame_tx, attached by bind.
// Keeps its own tick count and expected frame length from the format seen at
// the accepting edge, and checks idle level, start level, tick gating,
// stop level and frame length.
module uart_frame_tx_checker #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int MAX_TICKS = TICKS_PER_BIT * (DATA_W + 4),
    localparam int TC_W      = $clog2(MAX_TICKS + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       in_valid,
    input logic       in_ready,
    input logic       cfg_eight_bits,
    input logic [1:0] cfg_parity,
    input logic       cfg_two_stop,
    input logic       cfg_invert,
    input logic       busy,
    input logic       tx_line
);

    logic [TC_W-1:0] tick_cnt;
    logic [TC_W-1:0] exp_ticks;
    logic            chk_inv;

    // Own tick count and expected length per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            exp_ticks <= '0;
            chk_inv   <= 1'b0;
        end else if (in_valid && in_ready) begin
            tick_cnt  <= '0;
            chk_inv   <= cfg_invert;
            exp_ticks <= TC_W'(TICKS_PER_BIT * (1 + (cfg_eight_bits ? DATA_W : DATA_W - 1)
                          + ((cfg_parity != 2'b00) ? 1 : 0) + (cfg_two_stop ? 2 : 1)));
        end else if (busy && baud_tick) begin
            tick_cnt <= tick_cnt + TC_W'(1);
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line == !cfg_invert)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy); // R2

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_line == chk_inv)); // R3

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(tx_line)); // R10

    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tx_line) != chk_inv)); // R9

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tick_cnt == exp_ticks)); // R13

endmodule

bind uart_frame_tx uart_frame_tx_checker #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
) i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .baud_tick      (baud_tick),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .cfg_eight_bits (cfg_eight_bits),
    .cfg_parity     (cfg_parity),
    .cfg_two_stop   (cfg_two_stop),
    .cfg_invert     (cfg_invert),
    .busy           (busy),
    .tx_line        (tx_line)
);

// File: tb/test_uart_frame_tx.sv
// Sweeps every format combination with several characters and two tick
// rates, and models the expected line slot by slot from the requirements.
module test_uart_frame_tx;

    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       cfg_eight_bits = 1'b1;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       busy;
    logic       tx_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic  exp_bits [0:15];
    string exp_tag  [0:15];
    int    nslots;

    always #5 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick      (baud_tick),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .cfg_eight_bits (cfg_eight_bits),
        .cfg_parity     (cfg_parity),
        .cfg_two_stop   (cfg_two_stop),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_invert     (cfg_invert),
        .busy           (busy),
        .tx_line        (tx_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Raw slot list for one frame.
    // c: [0] eight bits, [2:1] parity, [3] two stop, [4] msb first, [5] invert
    task automatic build(input logic [7:0] d, input logic [5:0] c);
        int nch;
        int ones;
        nslots = 0;
        exp_bits[nslots] = 1'b0; exp_tag[nslots] = "R3 start"; nslots++;
        nch = c[0] ? 8 : 7;
        for (int i = 0; i < nch; i++) begin
            exp_bits[nslots] = d[c[4] ? (nch - 1 - i) : i];
            exp_tag[nslots]  = c[4] ? "R6 R4 msb-first char" : "R5 R4 lsb-first char";
            nslots++;
        end
        if (c[2:1] != 2'b00) begin
            ones = $countones(d & (c[0] ? 8'hFF : 8'h7F));
            if (c[2:1] == 2'b01)      exp_bits[nslots] = 1'((ones % 2));
            else if (c[2:1] == 2'b10) exp_bits[nslots] = 1'(1 - (ones % 2));
            else                      exp_bits[nslots] = 1'b0;
            exp_tag[nslots] = "R7 parity";
            nslots++;
        end
        for (int s = 0; s < (c[3] ? 2 : 1); s++) begin
            exp_bits[nslots] = 1'b1; exp_tag[nslots] = "R9 R8 stop"; nslots++;
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [5:0] c,
                             input int period, input bit perturb);
        int  ticks;
        int  n;
        int  slot;
        int  last_checked;
        int  bad;
        logic exp_line;
        build(d, c);
        @(negedge clk);
        in_data        = d;
        cfg_eight_bits = c[0];
        cfg_parity     = c[2:1];
        cfg_two_stop   = c[3];
        cfg_msb_first  = c[4];
        cfg_invert     = c[5];
        in_valid       = 1'b1;
        baud_tick      = 1'b1;
        check(in_ready == 1'b1, "R1 ready before frame", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        // R2: accepted; extra valid with other data must be ignored
        in_valid = perturb;
        in_data  = ~d;
        check(busy == 1'b1 && in_ready == 1'b0, "R2 busy after accept",
              int'({busy, in_ready}), 2);
        ticks = 0; n = 0; last_checked = -1; bad = 0;
        while (ticks < nslots * TPB) begin
            slot = ticks / TPB;
            exp_line = exp_bits[slot] ^ c[5];
            if (tx_line !== exp_line || busy !== 1'b1) bad++;
            if ((ticks % TPB) == TPB / 2 && last_checked != slot) begin
                last_checked = slot;
                check(tx_line === exp_line, $sformatf("%s R11 slot %0d", exp_tag[slot], slot),
                      int'(tx_line), int'(exp_line));
            end
            // R12: disturb format and data mid-frame
            if (perturb && ticks == 20) begin
                cfg_eight_bits = ~c[0];
                cfg_parity     = ~c[2:1];
                cfg_two_stop   = ~c[3];
                cfg_msb_first  = ~c[4];
            end
            if (ticks >= 40) in_valid = 1'b0;
            baud_tick = ((n % period) == 0);
            n++;
            @(posedge clk);
            if (baud_tick) ticks++;
            @(negedge clk);
        end
        baud_tick = 1'b0;
        check(bad == 0, perturb ? "R10 R12 line held per slot" : "R10 line held per slot", bad, 0);
        // R13: frame over exactly at the last tick of the last stop bit
        check(busy == 1'b0 && in_ready == 1'b1, "R13 ready after last stop (R4 R8 R9 length)",
              int'({busy, in_ready}), 1);
        check(tx_line == ~cfg_invert, "R1 R11 idle level after frame",
              int'(tx_line), int'(~cfg_invert));
        cfg_eight_bits = c[0];
        cfg_parity     = c[2:1];
        cfg_two_stop   = c[3];
        cfg_msb_first  = c[4];
    endtask

    initial begin
        logic [7:0] chars [0:2];
        chars[0] = 8'hA5;
        chars[1] = 8'h3C;
        chars[2] = 8'hD1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(tx_line == 1'b1, "R1 idle high", int'(tx_line), 1);
        cfg_invert = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b0, "R11 inverted idle", int'(tx_line), 0);
        cfg_invert = 1'b0;
        // R10: ticks while idle start nothing
        baud_tick = 1'b1;
        repeat (40) @(negedge clk);
        baud_tick = 1'b0;
        check(busy == 1'b0 && tx_line == 1'b1, "R10 idle ticks ignored",
              int'({busy, tx_line}), 1);
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 3; k++) begin
                run_frame(chars[k] ^ 8'(c * 7), 6'(c),
                          ((c % 8) == 0) ? 3 : 1, ((c + k) % 3) == 1);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule